// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block moves data from memory onto a byte-wide stream by following a linked chain of buffer descriptors. Each 64-byte descriptor names a buffer, its length and framing flags, and a pointer to the next descriptor. The walker fetches a descriptor one 32-bit word at a time over a simple request/response memory port. It then reads the buffer word by word and emits its bytes as they arrive, so no frame storage is needed. Afterwards it writes a completion status back into the descriptor and moves to the next one.

The surrounding register block loads the starting descriptor pointer and writes a tail pointer. The tail write clears the idle flag and arms the walk. A level-sensitive run input gates whether descriptors are processed at all. The walk stops after the tail descriptor has been handled, or earlier when a fetched descriptor is already marked complete. Either way the idle flag is raised. A one-cycle pulse reports each finished frame to the interrupt logic outside the block.

Descriptor layout, little-endian words by byte offset: 0 next pointer (low word used), 8 buffer address (low word used), 24 control, 28 status, 32 onward the application words.

Top module: `sgw_tx_walker`

## Requirements
- R1: After reset, idle_o is 1, cur_desc_o is 0, and mem_req_o, m_tvalid_o and frame_done_o are 0.
- R2: No memory request and no stream beat is issued while run_i is 0, even after a tail write has cleared idle_o. While idle_o is 1, nothing is issued either.
- R3: If the status word (offset 28) of a fetched descriptor has bit 31 set, the walker raises idle_o without any stream beat or memory write, and cur_desc_o keeps its value.
- R4: A descriptor's buffer is emitted as control[22:0] bytes, one per beat, starting at the buffer byte address and rising. The byte at address A sits in bits 8*(A mod 4)+7 : 8*(A mod 4) of the word at A with its low two bits cleared. Any start alignment is handled.
- R5: m_tlast_o is 1 only on the final byte of a descriptor whose control bit 26 (end of frame) is set.
- R6: A descriptor with control bit 27 (start of frame) loads its application words into m_tuser_o, word i (offset 32+4i) at bits 32i+31:32i. Descriptors without that bit leave m_tuser_o unchanged.
- R7: After each descriptor's buffer has been emitted, the walker writes the status word (offset 28) with control[22:0] OR 0x8000_0000.
- R8: frame_done_o pulses for exactly one cycle once per end-of-frame descriptor, after its final byte.
- R9: After the write-back, cur_desc_o takes the descriptor's next pointer (offset 0). If the descriptor just handled was the tail, idle_o rises and the walk stops.
- R10: A descriptor with length 0 produces no stream beat but is still written back (0x8000_0000) and advanced past.
- R11: While m_tvalid_o is 1 and m_tready_i is 0, m_tvalid_o, m_tdata_o and m_tlast_o hold.
- R12: The memory port has at most one read outstanding: after a read request is accepted, mem_req_o stays low until the data returns. No request is made while a stream beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Enables descriptor processing |
| cur_load_i | input | 1 | Loads the current descriptor pointer while stopped |
| cur_desc_i | input | ADDR_W | Value for the current pointer |
| tail_load_i | input | 1 | Loads the tail pointer and clears idle |
| tail_desc_i | input | ADDR_W | Value for the tail pointer |
| idle_o | output | 1 | Walk finished or not yet armed |
| cur_desc_o | output | ADDR_W | Current descriptor pointer |
| frame_done_o | output | 1 | One-cycle end-of-frame completion pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| m_tvalid_o | output | 1 | Stream beat valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | 8 | Stream byte |
| m_tlast_o | output | 1 | Last byte of frame |
| m_tuser_o | output | 32*APP_WORDS | Application sideband of the current frame |

## Verification
The hardest situation to reach is a frame spread over several descriptors. Such a frame has an unaligned buffer, an empty descriptor in the middle and a closing descriptor whose own application words must be ignored, all while both the memory port and the stream sink stall. The bench builds that chain in its memory model, turns on stall patterns on both ready inputs and places the tail on the closing descriptor. It then checks the byte order, the single last flag, the three write-backs and the sideband. A follow-up walk that lands on a pre-completed descriptor checks the early stop from the ports.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
   localparam int WORD_W   = 32;
   localparam int LEN_W    = 23;
   localparam int EOF_BIT  = 26;
   localparam int SOF_BIT  = 27;
   localparam int DONE_BIT = 31;
   localparam int STEP_W   = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FREQ,
      ST_FWAIT,
      ST_WREQ,
      ST_WWAIT,
      ST_EMIT,
      ST_WBACK,
      ST_ADV
   } sgw_state_e;

   // byte offset inside a descriptor of each fetch step:
   // status first, so a finished descriptor is detected before anything else
   function automatic logic [7:0] fetch_off(input logic [STEP_W-1:0] step);
      logic [7:0] r;
      case (step)
         5'd0:    r = 8'd28;
         5'd1:    r = 8'd24;
         5'd2:    r = 8'd0;
         5'd3:    r = 8'd8;
         default: r = 8'd32 + (({3'b000, step} - 8'd4) << 2);
      endcase
      return r;
   endfunction
endpackage

// File: rtl/sgw_byte_pick.sv
module sgw_byte_pick #(
   parameter int LANES = 4
) (
   input  logic [LANES*8-1:0]         word_i,
   input  logic [$clog2(LANES)-1:0]   sel_i,
   output logic [7:0]                 byte_o
);
   logic [7:0] lane [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word_i[g*8 +: 8];
   end

   assign byte_o = lane[sel_i];
endmodule

// File: rtl/sgw_sideband.sv
module sgw_sideband #(
   parameter int WORDS = 6,
   parameter int W     = 32,
   localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IW-1:0]    idx_i,
   input  logic [W-1:0]     d_i,
   output logic [WORDS*W-1:0] q_o
);
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               r <= '0;
         else if (we_i && (idx_i == IW'(g)))       r <= d_i;
      end
      assign q_o[g*W +: W] = r;
   end
endmodule

// File: rtl/sgw_tx_walker.sv
module sgw_tx_walker
   import sgw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int APP_WORDS = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run_i,
   input  logic                        cur_load_i,
   input  logic [ADDR_W-1:0]           cur_desc_i,
   input  logic                        tail_load_i,
   input  logic [ADDR_W-1:0]           tail_desc_i,
   output logic                        idle_o,
   output logic [ADDR_W-1:0]           cur_desc_o,
   output logic                        frame_done_o,
   output logic                        mem_req_o,
   output logic                        mem_we_o,
   output logic [ADDR_W-1:0]           mem_addr_o,
   output logic [WORD_W-1:0]           mem_wdata_o,
   input  logic                        mem_ready_i,
   input  logic                        mem_rvalid_i,
   input  logic [WORD_W-1:0]           mem_rdata_i,
   output logic                        m_tvalid_o,
   input  logic                        m_tready_i,
   output logic [7:0]                  m_tdata_o,
   output logic                        m_tlast_o,
   output logic [APP_WORDS*WORD_W-1:0] m_tuser_o
);
   localparam int IW = (APP_WORDS > 1) ? $clog2(APP_WORDS) : 1;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(3 + APP_WORDS);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("sgw_tx_walker: ADDR_W must lie in 8..32");
   end
   if (APP_WORDS < 1 || APP_WORDS > 8) begin : g_bad_app
      $error("sgw_tx_walker: APP_WORDS must lie in 1..8");
   end

   sgw_state_e          state;
   logic [STEP_W-1:0]   step;
   logic [ADDR_W-1:0]   cur, tail, nxt, bptr;
   logic [LEN_W-1:0]    len, rem;
   logic                sof, eof;
   logic [WORD_W-1:0]   word_q;
   logic                idle_r, done_r;

   logic                app_we;
   logic [IW-1:0]       app_idx;
   logic                beat_ok;
   logic                last_byte;
   sgw_state_e          data_state;

   assign beat_ok    = (state == ST_EMIT) && m_tready_i;
   assign last_byte  = (rem == LEN_W'(1));
   assign data_state = (len == '0) ? ST_WBACK : ST_WREQ;
   assign app_we     = (state == ST_FWAIT) && mem_rvalid_i && (step >= STEP_W'(4));
   assign app_idx    = IW'(step - STEP_W'(4));

   // memory request side
   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      case (state)
         ST_FREQ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = cur + ADDR_W'(fetch_off(step));
         end
         ST_WREQ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = {bptr[ADDR_W-1:2], 2'b00};
         end
         ST_WBACK: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = cur + ADDR_W'(28);
            mem_wdata_o = {1'b1, {(WORD_W-LEN_W-1){1'b0}}, len};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         step   <= '0;
         cur    <= '0;
         tail   <= '0;
         nxt    <= '0;
         bptr   <= '0;
         len    <= '0;
         rem    <= '0;
         sof    <= 1'b0;
         eof    <= 1'b0;
         word_q <= '0;
         idle_r <= 1'b1;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (tail_load_i) begin
            tail   <= tail_desc_i;
            idle_r <= 1'b0;
         end
         case (state)
            ST_IDLE: begin
               if (cur_load_i) cur <= cur_desc_i;
               if (run_i && !idle_r) begin
                  step  <= '0;
                  state <= ST_FREQ;
               end
            end
            ST_FREQ: if (mem_ready_i) state <= ST_FWAIT;
            ST_FWAIT: if (mem_rvalid_i) begin
               step  <= step + STEP_W'(1);
               state <= ST_FREQ;
               case (step)
                  5'd0: if (mem_rdata_i[DONE_BIT]) begin
                     idle_r <= 1'b1;
                     state  <= ST_IDLE;
                  end
                  5'd1: begin
                     len <= mem_rdata_i[LEN_W-1:0];
                     sof <= mem_rdata_i[SOF_BIT];
                     eof <= mem_rdata_i[EOF_BIT];
                  end
                  5'd2: nxt <= mem_rdata_i[ADDR_W-1:0];
                  5'd3: begin
                     bptr <= mem_rdata_i[ADDR_W-1:0];
                     rem  <= len;
                     if (!sof) state <= data_state;
                  end
                  default: if (step == LAST_STEP) state <= data_state;
               endcase
            end
            ST_WREQ: if (mem_ready_i) state <= ST_WWAIT;
            ST_WWAIT: if (mem_rvalid_i) begin
               word_q <= mem_rdata_i;
               state  <= ST_EMIT;
            end
            ST_EMIT: if (beat_ok) begin
               bptr <= bptr + ADDR_W'(1);
               rem  <= rem - LEN_W'(1);
               if (last_byte)               state <= ST_WBACK;
               else if (bptr[1:0] == 2'b11) state <= ST_WREQ;
            end
            ST_WBACK: if (mem_ready_i) begin
               done_r <= eof;
               state  <= ST_ADV;
            end
            ST_ADV: begin
               cur <= nxt;
               if (cur == tail) idle_r <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   sgw_byte_pick #(.LANES(WORD_W/8)) u_pick (
      .word_i (word_q),
      .sel_i  (bptr[1:0]),
      .byte_o (m_tdata_o)
   );

   sgw_sideband #(.WORDS(APP_WORDS), .W(WORD_W)) u_sb (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (app_we),
      .idx_i (app_idx),
      .d_i   (mem_rdata_i),
      .q_o   (m_tuser_o)
   );

   assign m_tvalid_o   = (state == ST_EMIT);
   assign m_tlast_o    = (state == ST_EMIT) && eof && last_byte;
   assign idle_o       = idle_r;
   assign cur_desc_o   = cur;
   assign frame_done_o = done_r;
endmodule

// File: rtl/sgw_tx_walker_chk.sv
module sgw_tx_walker_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       idle_o,
   input logic       frame_done_o,
   input logic       mem_req_o,
   input logic       mem_we_o,
   input logic       mem_ready_i,
   input logic       m_tvalid_o,
   input logic       m_tready_i,
   input logic [7:0] m_tdata_o,
   input logic       m_tlast_o
);
   // R11: a stalled beat keeps its contents
   a_r11_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o));

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |=> !frame_done_o);

   // R2: an idle walker touches neither memory nor the stream
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> !mem_req_o && !m_tvalid_o);

   // R12: one outstanding read
   a_r12_one_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_ready_i && !mem_we_o |=> !mem_req_o);

   // R12: no request while a byte is on offer
   a_r12_no_req_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid_o |-> !mem_req_o);

   // R5: last flag only rides on a valid beat
   a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast_o |-> m_tvalid_o);
endmodule

bind sgw_tx_walker sgw_tx_walker_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .idle_o       (idle_o),
   .frame_done_o (frame_done_o),
   .mem_req_o    (mem_req_o),
   .mem_we_o     (mem_we_o),
   .mem_ready_i  (mem_ready_i),
   .m_tvalid_o   (m_tvalid_o),
   .m_tready_i   (m_tready_i),
   .m_tdata_o    (m_tdata_o),
   .m_tlast_o    (m_tlast_o)
);

// File: tb/sgw_tx_walker_tb.sv
module sgw_tx_walker_tb;
   localparam int AW  = 32;
   localparam int APP = 6;
   localparam int MW  = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            run_i = 1'b0, cur_load_i = 1'b0, tail_load_i = 1'b0;
   logic [AW-1:0]   cur_desc_i = '0, tail_desc_i = '0;
   logic            idle_o, frame_done_o;
   logic [AW-1:0]   cur_desc_o;
   logic            mem_req_o, mem_we_o, mem_ready_i, mem_rvalid_i;
   logic [AW-1:0]   mem_addr_o;
   logic [31:0]     mem_wdata_o, mem_rdata_i;
   logic            m_tvalid_o, m_tready_i, m_tlast_o;
   logic [7:0]      m_tdata_o;
   logic [APP*32-1:0] m_tuser_o;

   sgw_tx_walker #(.ADDR_W(AW), .APP_WORDS(APP)) u_dut (.*);

   // memory model, host poke port, monitors
   logic [31:0] mem [MW];
   logic        hw_en = 1'b0;
   logic [AW-1:0] hw_addr = '0;
   logic [31:0] hw_data = '0;
   logic        clr = 1'b0;
   logic        bp_on = 1'b0;
   int unsigned cyc = 0;
   int          nbeat, nwr, nreq, ndone;
   logic [7:0]  beat_d [64];
   logic        beat_l [64];
   logic [AW-1:0] wr_a [16];
   logic [31:0] wr_d [16];

   always @(negedge clk) begin
      cyc         <= cyc + 1;
      m_tready_i  <= bp_on ? ((cyc % 3) != 0) : 1'b1;
      mem_ready_i <= bp_on ? cyc[0] : 1'b1;
   end

   always @(posedge clk) begin
      mem_rvalid_i <= 1'b0;
      if (hw_en) mem[hw_addr[11:2]] <= hw_data;
      if (clr) begin
         nbeat <= 0; nwr <= 0; nreq <= 0; ndone <= 0;
      end else begin
         if (mem_req_o) nreq <= nreq + 1;
         if (frame_done_o) ndone <= ndone + 1;
         if (m_tvalid_o && m_tready_i && nbeat < 64) begin
            beat_d[nbeat] <= m_tdata_o;
            beat_l[nbeat] <= m_tlast_o;
            nbeat <= nbeat + 1;
         end
         if (mem_req_o && mem_ready_i && mem_we_o && nwr < 16) begin
            wr_a[nwr] <= mem_addr_o;
            wr_d[nwr] <= mem_wdata_o;
            nwr <= nwr + 1;
         end
      end
      if (mem_req_o && mem_ready_i) begin
         if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
         else begin
            mem_rvalid_i <= 1'b1;
            mem_rdata_i  <= mem[mem_addr_o[11:2]];
         end
      end
   end

   int nvec = 0, nerr = 0;

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) ^ (a >> 8));
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk); hw_en = 1'b1; hw_addr = AW'(a); hw_data = d;
      @(negedge clk); hw_en = 1'b0;
   endtask

   task automatic put_desc(input int base, input int nx, input int bf,
                           input logic [31:0] ctrl, input logic [31:0] st,
                           input logic [31:0] seed);
      poke(base + 0, 32'(nx));  poke(base + 4, 0);
      poke(base + 8, 32'(bf));  poke(base + 12, 0);
      poke(base + 16, 0);       poke(base + 20, 0);
      poke(base + 24, ctrl);    poke(base + 28, st);
      for (int i = 0; i < APP; i++) poke(base + 32 + 4*i, seed + 32'(i));
   endtask

   task automatic clear_mon();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic load_cur(input int a);
      @(negedge clk); cur_load_i = 1'b1; cur_desc_i = AW'(a);
      @(negedge clk); cur_load_i = 1'b0;
   endtask

   task automatic load_tail(input int a);
      @(negedge clk); tail_load_i = 1'b1; tail_desc_i = AW'(a);
      @(negedge clk); tail_load_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000 && !idle_o; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 idle", idle_o, 1);
      check("R1 req", mem_req_o, 0);
      check("R1 tvalid", m_tvalid_o, 0);
      check("R1 done", frame_done_o, 0);
      check("R1 cur", cur_desc_o, 0);
   endtask

   task automatic t_norun();
      put_desc(32'h000, 32'h040, 32'h200, 32'h0C00_0007, 0, 32'hA000_0000);
      clear_mon();
      load_cur(32'h000);
      load_tail(32'h000);
      repeat (20) @(negedge clk);
      check("R2 no request without run", nreq, 0);
      check("R2 no beat without run", nbeat, 0);
      check("R2 idle cleared by tail", idle_o, 0);
   endtask

   task automatic t_single();
      run_i = 1'b1;
      wait_idle();
      check("R9 idle after tail", idle_o, 1);
      check("R4 beat count", nbeat, 7);
      for (int i = 0; i < 7; i++) begin
         check("R4 byte", beat_d[i], pat(32'h200 + i));
         check("R5 last", beat_l[i], i == 6);
      end
      for (int i = 0; i < APP; i++)
         check("R6 sideband", m_tuser_o[i*32 +: 32], 32'hA000_0000 + 32'(i));
      check("R7 wb count", nwr, 1);
      check("R7 wb addr", wr_a[0], 32'h01C);
      check("R7 wb data", wr_d[0], 32'h8000_0007);
      check("R8 done count", ndone, 1);
      check("R9 next ptr", cur_desc_o, 32'h040);
   endtask

   task automatic t_chain();
      put_desc(32'h040, 32'h080, 32'h301, 32'h0800_0005, 0, 32'hB000_0000);
      put_desc(32'h080, 32'h0C0, 32'h000, 32'h0000_0000, 0, 32'hD000_0000);
      put_desc(32'h0C0, 32'h100, 32'h342, 32'h0400_0006, 0, 32'hC000_0000);
      put_desc(32'h100, 32'h140, 32'h3A0, 32'h0C00_0004, 32'h8000_0000, 32'hE000_0000);
      clear_mon();
      bp_on = 1'b1;
      load_tail(32'h0C0);
      wait_idle();
      bp_on = 1'b0;
      check("R4 chain beat count", nbeat, 11);
      for (int i = 0; i < 11; i++) begin
         check("R11 R4 chain byte", beat_d[i], (i < 5) ? pat(32'h301 + i) : pat(32'h342 + i - 5));
         check("R5 chain last", beat_l[i], i == 10);
      end
      check("R6 latched on start only", m_tuser_o[31:0], 32'hB000_0000);
      check("R6 word5", m_tuser_o[5*32 +: 32], 32'hB000_0005);
      check("R7 chain wb count", nwr, 3);
      check("R7 wb first", wr_d[0], 32'h8000_0005);
      check("R10 empty wb addr", wr_a[1], 32'h09C);
      check("R10 empty wb data", wr_d[1], 32'h8000_0000);
      check("R7 wb last", wr_d[2], 32'h8000_0006);
      check("R8 one done per frame", ndone, 1);
      check("R9 chain next ptr", cur_desc_o, 32'h100);
      check("R9 chain idle", idle_o, 1);
   endtask

   task automatic t_complete();
      clear_mon();
      load_tail(32'h140);
      wait_idle();
      check("R3 idle on complete", idle_o, 1);
      check("R3 no beats", nbeat, 0);
      check("R3 no writes", nwr, 0);
      check("R3 ptr kept", cur_desc_o, 32'h100);
      check("R3 no done", ndone, 0);
   endtask

   initial begin
      clr = 1'b1;
      for (int w = 0; w < MW; w++) begin
         @(negedge clk);
         hw_en = 1'b1; hw_addr = AW'(w*4);
         hw_data = {pat(w*4+3), pat(w*4+2), pat(w*4+1), pat(w*4)};
      end
      @(negedge clk); hw_en = 1'b0;
      t_reset();
      rst_n = 1'b1;
      @(negedge clk); clr = 1'b0;
      @(negedge clk);
      fork
         begin
            t_norun();
            t_single();
            t_chain();
            t_complete();
         end
         begin
            repeat (150000) @(posedge clk);
            nvec++; nerr++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule